// File: doc/BRIEF.md
# Seat-Belt Reminder Alarm Controller

This block raises a driver warning when the ignition is on and the seat belt is left open. It watches two switch levels, key-on and belt-fastened, plus a periodic time-unit tick supplied from outside. When the key turns on, it emits a one-cycle timer-start pulse and starts counting ticks. If the belt is still open after a first threshold of ticks, the alarm output rises. The alarm stays up until a second threshold is reached, the belt is fastened or the key is turned off.

The controller is a three-state machine (idle, waiting, alarming), and exactly one state is active at a time. It carries its own saturating tick counter, which is cleared while idle. A new run starts only on a fresh off-to-on change of the key, so a held key does not retrigger the reminder after it has been dismissed. Both thresholds are parameters, and the first must be smaller than the second. Debouncing, tick generation and driving a buzzer or lamp are handled elsewhere.

Top module: `belt_alarm_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, alarm_o and timer_start_o are 0 and the controller is idle until a key-on change is seen.
- R2: In idle, a change of key_on_i from 0 to 1, sampled on consecutive clock edges, gives timer_start_o = 1 for exactly one cycle, starts a run and clears the tick count.
- R3: While waiting, key_on_i = 0 or belt_on_i = 1 ends the run at the next edge, with no alarm raised.
- R4: While waiting with key on and belt open, the alarm rises on the edge after the tick count reaches T_ON_TICKS. With tick_i held high from the key-on edge, alarm_o first reads 1 at the T_ON_TICKS+2nd sample after that edge.
- R5: With key on, belt open and tick_i held high, alarm_o stays 1 for exactly T_OFF_TICKS-T_ON_TICKS cycles and then falls.
- R6: While alarming, belt_on_i = 1 or key_on_i = 0, alone or together, drops alarm_o at the next edge.
- R7: Ticks are counted only while waiting or alarming. Ticks in idle have no effect on the next run's timing, and the count saturates at T_OFF_TICKS.
- R8: After a run ends with the key still held on, no new timer_start_o pulse and no alarm occur until the key goes off and on again. That off-then-on change starts a fresh run.
- R9: alarm_o and timer_start_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_on_i | input | 1 | Ignition key on level |
| belt_on_i | input | 1 | Seat belt fastened level |
| tick_i | input | 1 | One-cycle time-unit tick |
| alarm_o | output | 1 | Alarm enable, registered |
| timer_start_o | output | 1 | One-cycle pulse when a run starts |

## Verification
The hardest case to reach from the ports is the full alarm window ending on the upper threshold. That needs the key held on and the belt held open for more than T_OFF_TICKS ticks in a row, which random switch activity rarely produces. Directed runs hold both levels steady with the tick high and count the cycles to the alarm's rise and fall. A second directed run dismisses the reminder and keeps the key on, to show that no new run starts. Random stimulus with rare switch changes then covers mixed exit conditions against a bench reference model.

// File: rtl/belt_alarm_pkg.sv
package belt_alarm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ALARM = 2'd2
  } belt_st_e;
endpackage

// File: rtl/belt_alarm_timer.sv
module belt_alarm_timer
  import belt_alarm_pkg::*;
#(
  parameter int unsigned T_OFF_TICKS = 10,
  localparam int unsigned CW = $clog2(T_OFF_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  belt_st_e      state_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(T_OFF_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (state_i == ST_IDLE) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R7
  AST_CNT_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |=> (cnt_q == '0)); // R7
  AST_CNT_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && state_i != ST_IDLE) |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/belt_alarm_fsm.sv
module belt_alarm_fsm
  import belt_alarm_pkg::*;
#(
  parameter int unsigned T_ON_TICKS  = 5,
  parameter int unsigned T_OFF_TICKS = 10,
  localparam int unsigned CW = $clog2(T_OFF_TICKS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          key_on_i,
  input  logic          belt_on_i,
  input  logic [CW-1:0] cnt_i,
  output belt_st_e      state_o,
  output logic          alarm_o,
  output logic          start_o
);
  localparam logic [CW-1:0] LIM_ON  = CW'(T_ON_TICKS);
  localparam logic [CW-1:0] LIM_OFF = CW'(T_OFF_TICKS);

  belt_st_e state_q, state_d;
  logic     key_q, key_rise, cancel;

  assign key_rise = key_on_i && !key_q;
  assign cancel   = !key_on_i || belt_on_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (key_rise) state_d = ST_WAIT;
      ST_WAIT: begin
        if (cancel)               state_d = ST_IDLE;
        else if (cnt_i >= LIM_ON) state_d = ST_ALARM;
      end
      ST_ALARM: if (cancel || cnt_i >= LIM_OFF) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      key_q   <= 1'b0;
      alarm_o <= 1'b0;
      start_o <= 1'b0;
    end else begin
      state_q <= state_d;
      key_q   <= key_on_i;
      alarm_o <= (state_d == ST_ALARM);
      start_o <= (state_q == ST_IDLE) && (state_d == ST_WAIT);
    end
  end

  assign state_o = state_q;

  AST_ALARM_TRACKS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o == (state_q == ST_ALARM)); // R9
  AST_CANCEL_IN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && cancel) |=> (state_q == ST_IDLE && !alarm_o)); // R3
  AST_CANCEL_IN_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && cancel) |=> !alarm_o); // R6
  AST_TIMEOUT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && cnt_i >= LIM_OFF) |=> !alarm_o); // R5
endmodule

// File: rtl/belt_alarm_ctrl.sv
module belt_alarm_ctrl
  import belt_alarm_pkg::*;
#(
  parameter int unsigned T_ON_TICKS  = 5,
  parameter int unsigned T_OFF_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_on_i,
  input  logic belt_on_i,
  input  logic tick_i,
  output logic alarm_o,
  output logic timer_start_o
);
  localparam int unsigned CW = $clog2(T_OFF_TICKS + 1);

  belt_st_e      state;
  logic [CW-1:0] cnt;

  belt_alarm_timer #(.T_OFF_TICKS(T_OFF_TICKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .tick_i  (tick_i),
    .cnt_o   (cnt)
  );

  belt_alarm_fsm #(.T_ON_TICKS(T_ON_TICKS), .T_OFF_TICKS(T_OFF_TICKS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_on_i  (key_on_i),
    .belt_on_i (belt_on_i),
    .cnt_i     (cnt),
    .state_o   (state),
    .alarm_o   (alarm_o),
    .start_o   (timer_start_o)
  );

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_start_o |=> !timer_start_o); // R2
  AST_START_CLEARS_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_start_o |-> (cnt == '0)); // R2
  AST_NO_ALARM_WITH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alarm_o && timer_start_o)); // R9
  AST_ALARM_AFTER_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_o) |-> ($past(cnt) >= CW'(T_ON_TICKS))); // R4
endmodule

// File: tb/belt_alarm_ctrl_tb_top.sv
module belt_alarm_ctrl_tb_top;
  localparam int unsigned T_ON  = 5;
  localparam int unsigned T_OFF = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key = 1'b0, belt = 1'b0, tick = 1'b0;
  logic alarm, start;
  int   total = 0, bad = 0, cyc = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  belt_alarm_ctrl #(.T_ON_TICKS(T_ON), .T_OFF_TICKS(T_OFF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .key_on_i(key), .belt_on_i(belt),
    .tick_i(tick), .alarm_o(alarm), .timer_start_o(start)
  );

  // reference model: 0 idle, 1 wait, 2 alarm
  int   m_st = 0, m_cnt = 0;
  logic m_kq = 0, m_alarm = 0, m_start = 0;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_kq = 0; m_alarm = 0; m_start = 0; m_tag = "R1";
    end else begin
      int nx;
      logic cancel;
      cancel = !key || belt;
      nx = m_st;
      m_start = 0;
      case (m_st)
        0: if (key && !m_kq) begin nx = 1; m_start = 1; m_tag = "R2"; end
           else m_tag = "R8";
        1: if (cancel) begin nx = 0; m_tag = "R3"; end
           else if (m_cnt >= T_ON) begin nx = 2; m_tag = "R4"; end
           else m_tag = "R7";
        default: if (cancel) begin nx = 0; m_tag = "R6"; end
           else if (m_cnt >= T_OFF) begin nx = 0; m_tag = "R5"; end
           else m_tag = "R7";
      endcase
      if (m_st == 0) m_cnt = 0;
      else if (tick && m_cnt < T_OFF) m_cnt = m_cnt + 1;
      m_kq = key;
      m_st = nx;
      m_alarm = (nx == 2);
    end
  end

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic k, logic b, logic t);
    @(negedge clk);
    chk(m_tag, alarm, m_alarm);
    chk(m_tag, start, m_start);
    chk("R9", alarm && start, 1'b0);
    key = k; belt = b; tick = t;
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 0; key = 0; belt = 0; tick = 0;
    @(negedge clk);
    chk("R1", alarm, 1'b0);
    chk("R1", start, 1'b0);
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, dur;
    void'($urandom(32'd1234));
    reset_dut();
    step(0, 0, 0); step(0, 0, 0);
    chk("R1", alarm, 1'b0);

    // R4/R5 full window, counted independently of the model
    step(0, 1, 1); // ticks in idle with belt on: R7 no effect
    step(0, 0, 1);
    step(1, 0, 1);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) chk("R2", start, 1'b1);
      if (n == 2) chk("R2", start, 1'b0);
    end while (!alarm && n < 50);
    chk("R4", n == T_ON + 2, 1'b1);
    dur = 0;
    while (alarm && dur < 50) begin @(negedge clk); dur++; end
    chk("R5", dur == T_OFF - T_ON, 1'b1);

    // R8: key still on after timeout, nothing restarts
    for (int i = 0; i < 2 * T_OFF; i++) begin
      @(negedge clk);
      chk("R8", alarm, 1'b0);
      chk("R8", start, 1'b0);
    end
    key = 0;
    @(negedge clk); key = 1;
    @(negedge clk); chk("R8", start, 1'b1);

    // R3: belt cancels in wait
    step(1, 1, 1);
    for (int i = 0; i < T_OFF + 3; i++) step(1, 1, 1);
    chk("R3", alarm, 1'b0);

    // R6: simultaneous belt and key off while alarming
    step(0, 0, 1);
    step(1, 0, 1);
    for (int i = 0; i < T_ON + 2; i++) step(1, 0, 1);
    chk("R6", alarm, 1'b1);
    step(0, 1, 1);
    step(0, 0, 0);
    chk("R6", alarm, 1'b0);

    // reset in the middle of a run
    step(1, 0, 1);
    reset_dut();

    // random run against the model
    for (int i = 0; i < 20000; i++) begin
      logic k, b, t;
      k = key; b = belt;
      if ($urandom_range(0, 24) == 0) k = ~k;
      if ($urandom_range(0, 29) == 0) b = ~b;
      t = ($urandom_range(0, 2) != 0);
      step(k, b, t);
    end
    step(0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule